// File: doc/BRIEF.md
# Variable-Rate Serial Clock Generator

This block produces the serial clock of an SPI master from the system clock. In fixed-rate mode every half-period of the serial clock lasts `div_a_i + 1` system cycles. In variable-rate mode each serial clock cycle instead runs at one of two rates. A 32-bit pattern word picks, cycle by cycle, whether the primary divider `div_a_i` or the alternate divider `div_b_i` sets both half-periods of that cycle.

A transfer starts when `run_i` is seen high while the generator is idle. The generator then counts one half-period at the idle level, raises the clock to its active level, counts a second half-period and returns the clock to idle. The divider for each serial cycle is fixed when that cycle begins. Two one-cycle strobes go to the shift engine: `lead_o` marks the move away from the idle level and `trail_o` marks the return to it.

Dropping `run_i` stops the generator without a clipped pulse. If the clock has not yet left idle, the generator stops at once. If the clock is active, the current cycle is finished first. The idle level is set by `cpol_i`.

Top module: `spi_varclk_gen`

## Requirements
- R1: While `rst_ni` is low and right after reset, `sclk_o` equals `cpol_i`, and `lead_o` and `trail_o` are 0.
- R2: With `var_en_i` = 0, each half-period of the serial clock lasts `div_a_i + 1` system clock cycles.
- R3: With `var_en_i` = 1, serial cycle n of a transfer uses `div_b_i` when bit (n mod 32) of `pattern_i` is 1 and `div_a_i` when it is 0, for both of its half-periods.
- R4: The pattern index restarts at bit 0 at the start of every transfer, whatever it reached in the previous transfer.
- R5: After serial cycle 31 the pattern index wraps, so serial cycle 32 uses bit 0 again.
- R6: With `var_en_i` = 0, `pattern_i` and `div_b_i` have no effect on `sclk_o`, `lead_o` or `trail_o`.
- R7: `lead_o` is high for exactly one system cycle, the first cycle in which `sclk_o` is at the active level (`!cpol_i`). `trail_o` is high for exactly one cycle, the first cycle in which `sclk_o` is back at idle. The two strobes are never high together.
- R8: If `run_i` is seen low while the clock is still in the idle-level half of a cycle, the generator returns to idle with no leading edge.
- R9: If `run_i` is seen low while the clock is active, the cycle runs to its normal trailing edge and the generator then stays idle.
- R10: When not running, `sclk_o` rests at `cpol_i` (0 or 1).
- R11: The first leading edge appears `d + 1` rising clock edges after the edge that samples `run_i` high, where d is the divider chosen for serial cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Start / keep running the serial clock |
| var_en_i | input | 1 | Enables variable-rate mode |
| div_a_i | input | 16 | Primary half-period divider |
| div_b_i | input | 16 | Alternate half-period divider |
| pattern_i | input | 32 | Per-cycle rate selection; bit n is for serial cycle n |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe on the leading edge |
| trail_o | output | 1 | One-cycle strobe on the trailing edge |

## Verification
Take the rising edge that samples `run_i` high as edge 0. Serial cycle i has its leading strobe at edge `base_i + d_i + 1` and its trailing strobe at edge `base_i + 2(d_i + 1)`. Here `base_0` = 0, `base_{i+1}` is the trailing edge of cycle i, and `d_i` is the divider that R2, R3 and R5 choose for cycle i. The bench builds these edge numbers by arithmetic before each transfer. It then compares `sclk_o`, `lead_o` and `trail_o` against them at every falling edge, so each registered output is read half a cycle after the edge that updated it. A stop request is driven on the falling edge just after the last leading strobe. The checks then cover the final trailing edge and several idle cycles after it.

// File: rtl/spi_varclk_pkg.sv
package spi_varclk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_varclk_sel.sv
module spi_varclk_sel #(
  parameter int DIV_W = 16,
  parameter int PAT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             adv_i,
  input  logic             var_en_i,
  input  logic [PAT_W-1:0] pattern_i,
  input  logic [DIV_W-1:0] div_a_i,
  input  logic [DIV_W-1:0] div_b_i,
  output logic [DIV_W-1:0] div_o
);
  localparam int IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAT_W - 1);

  logic [IDX_W-1:0] idx_q, idx_nxt;

  always_comb begin
    if (start_i)     idx_nxt = '0;
    else if (adv_i)  idx_nxt = (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
    else             idx_nxt = idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_nxt;
  end

  // divider for the cycle about to begin
  assign div_o = (var_en_i && pattern_i[idx_nxt]) ? div_b_i : div_a_i;

  // R5
  idx_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !start_i && idx_q == IDX_LAST) |=> (idx_q == '0));
endmodule

// File: rtl/spi_varclk_cnt.sv
module spi_varclk_cnt #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] lim_i,
  output logic             hit_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + DIV_W'(1);
  end

  assign hit_o = en_i && (cnt_q == lim_i);

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= lim_i));
endmodule

// File: rtl/spi_varclk_gen.sv
module spi_varclk_gen
  import spi_varclk_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int PAT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             var_en_i,
  input  logic [DIV_W-1:0] div_a_i,
  input  logic [DIV_W-1:0] div_b_i,
  input  logic [PAT_W-1:0] pattern_i,
  input  logic             cpol_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  phase_e           state_q;
  logic [DIV_W-1:0] lim_q, div_nxt;
  logic             hit, start, adv, cnt_en, cnt_clr;
  logic             act_q, lead_q, trail_q;

  assign start   = (state_q == PH_IDLE) && run_i;
  assign adv     = (state_q == PH_ACTIVE) && hit;
  assign cnt_en  = (state_q != PH_IDLE);
  assign cnt_clr = (state_q == PH_IDLE) || hit;

  spi_varclk_sel #(.DIV_W(DIV_W), .PAT_W(PAT_W)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .adv_i     (adv),
    .var_en_i  (var_en_i),
    .pattern_i (pattern_i),
    .div_a_i   (div_a_i),
    .div_b_i   (div_b_i),
    .div_o     (div_nxt)
  );

  spi_varclk_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en),
    .clr_i  (cnt_clr),
    .lim_i  (lim_q),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      lim_q   <= '0;
      act_q   <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      unique case (state_q)
        PH_IDLE: begin
          if (run_i) begin
            state_q <= PH_SETUP;
            lim_q   <= div_nxt;
          end
        end
        PH_SETUP: begin
          // stop before any edge: no pulse is started
          if (!run_i) begin
            state_q <= PH_IDLE;
          end else if (hit) begin
            state_q <= PH_ACTIVE;
            act_q   <= 1'b1;
            lead_q  <= 1'b1;
          end
        end
        PH_ACTIVE: begin
          // an active half always completes
          if (hit) begin
            act_q   <= 1'b0;
            trail_q <= 1'b1;
            if (run_i) begin
              state_q <= PH_SETUP;
              lim_q   <= div_nxt;
            end else begin
              state_q <= PH_IDLE;
            end
          end
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign sclk_o  = act_q ^ cpol_i;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_q && trail_q));
  // R7
  lead_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_q |-> (act_q && !$past(act_q)));
  // R9
  no_partial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> trail_q);
  // R8
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_SETUP && !run_i) |=> (!act_q && !lead_q));
  // R10
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_IDLE) |-> (sclk_o == cpol_i));
endmodule

// File: tb/spi_varclk_gen_tb.sv
module spi_varclk_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        ve = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [31:0] pat = '0;
  logic        pol = 1'b0;
  logic        sclk, lead, trail;
  int          cyc = 0;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_varclk_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .var_en_i(ve),
    .div_a_i(a), .div_b_i(b), .pattern_i(pat), .cpol_i(pol),
    .sclk_o(sclk), .lead_o(lead), .trail_o(trail)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Runs n serial cycles, stopping after the last leading edge.
  task automatic burst(input int n, input bit e, input logic [15:0] da,
                       input logic [15:0] db, input logic [31:0] p,
                       input bit cp, input string tag);
    int lt[64];
    int tt[64];
    int base = 0;
    int start;
    int leads = 0;
    int first_lead = -1;
    for (int i = 0; i < n; i++) begin
      int d = (e && p[i % 32]) ? int'(db) : int'(da);
      lt[i] = base + d + 1;
      tt[i] = base + 2 * (d + 1);
      base  = tt[i];
    end
    @(negedge clk);
    ve = e; a = da; b = db; pat = p; pol = cp; run = 1'b1;
    start = cyc + 1;
    forever begin
      int rel;
      bit exp_act = 1'b0;
      bit exp_lead = 1'b0;
      bit exp_trail = 1'b0;
      @(negedge clk);
      rel = cyc - start;
      for (int i = 0; i < n; i++) begin
        if (rel >= lt[i] && rel < tt[i]) exp_act = 1'b1;
        if (rel == lt[i]) exp_lead = 1'b1;
        if (rel == tt[i]) exp_trail = 1'b1;
      end
      if (lead) begin
        leads++;
        if (first_lead < 0) first_lead = rel;
      end
      chk(sclk == (exp_act ^ cp), tag, $sformatf("sclk at edge %0d", rel),
          int'(sclk), int'(exp_act ^ cp));
      chk({lead, trail} == {exp_lead, exp_trail}, tag,
          $sformatf("strobes at edge %0d", rel),
          int'({lead, trail}), int'({exp_lead, exp_trail}));
      if (rel == lt[n-1]) run = 1'b0;
      if (rel >= tt[n-1] + 4) break;
    end
    // R7 one leading strobe per serial cycle
    chk(leads == n, tag, "R7 leading strobe count", leads, n);
    // R11 first leading edge position
    chk(first_lead == lt[0], tag, "R11 first leading edge", first_lead, lt[0]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    pol = 1'b1;
    #(CLK_PERIOD * 2 + 1);
    chk(sclk == 1'b1 && !lead && !trail, "R1", "outputs in reset",
        int'({sclk, lead, trail}), 4);
    @(negedge clk); rst_n = 1'b1;
    pol = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0 && !lead && !trail, "R1", "outputs after reset",
        int'({sclk, lead, trail}), 0);

    // R2 fixed rate, smallest divider
    burst(3, 1'b0, 16'd0, 16'd9, 32'h0, 1'b0, "R2");
    // R10 idle high, R2 wider divider
    burst(4, 1'b0, 16'd3, 16'd0, 32'h0, 1'b1, "R10");
    // R6 pattern and alternate divider ignored when variable mode is off
    burst(5, 1'b0, 16'd1, 16'd7, 32'hFFFF_FFFF, 1'b0, "R6");
    // R3 R5 variable mode across the wrap
    burst(34, 1'b1, 16'd0, 16'd2, 32'hA5C3_0F01, 1'b0, "R3_R5");
    // R4 restart uses bit 0 again
    burst(3, 1'b1, 16'd2, 16'd0, 32'h0000_0002, 1'b1, "R4");
    // R9 stop during active half covered by every burst; another one
    burst(2, 1'b1, 16'd4, 16'd1, 32'h0000_0001, 1'b0, "R9");

    // R8 stop during idle-level half: no edge at all
    @(negedge clk);
    ve = 1'b0; a = 16'd4; pol = 1'b0; run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      chk(sclk == 1'b0 && !lead && !trail, "R8", "idle after early stop",
          int'({sclk, lead, trail}), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule